// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This unit gathers three interrupt events from a serial peripheral: transfer complete, receive data ready and receive overflow. It keeps each event in a sticky raw status bit. It then qualifies those bits with three enable bits that sit at scattered positions in the peripheral's control word, and drives a single level-sensitive interrupt line.

Software acknowledges events through a write-one-to-clear strobe. Writes aimed at the two status registers are presented on a separate strobe, and the unit ignores them. Address decoding and event generation happen outside this unit. The strobes and the control word arrive already decoded.

The enable bits are moved from their control-word positions onto the common raw, masked and clear layout by a parameterised remap. This keeps the raw, masked and clear words bit-aligned, so one index names the same source in all three.

Top module: `mis_irq_unit`

## Requirements
- R1: Raw status layout: bit 0 is transfer done, bit 1 is receive ready, bit 2 is receive overflow. All higher bits of the raw and masked words read zero.
- R2: A one-cycle pulse on an event input sets its raw bit at the next clock edge. The bit then stays set with no further pulses until it is cleared.
- R3: When the clear strobe is high, a one in bit 0, 1 or 2 of the write data clears the matching raw bit at the next edge. Zero bits, bits above 2, and any data while the strobe is low have no effect.
- R4: When an event pulse and a clear of the same bit arrive in the same cycle, the bit is set after the edge.
- R5: The masked word equals raw AND remapped enables in the same cycle, with no clock delay. Control bit 5 enables transfer done (masked bit 0), control bit 4 enables receive ready (masked bit 1) and control bit 6 enables receive overflow (masked bit 2). No other control bit affects the masked word.
- R6: The interrupt output is high in exactly the cycles in which any masked bit is set.
- R7: A write on the status-register write strobe, whatever its data, leaves the raw status unchanged.
- R8: While reset is active the raw word, the masked word and the interrupt output are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 3 | Event pulses in raw layout (0 done, 1 rx ready, 2 overflow) |
| ctrl_word | input | 32 | Peripheral control word carrying the enables |
| clr_we | input | 1 | Write strobe for the write-one-to-clear register |
| stat_we | input | 1 | Write strobe aimed at the raw or masked status register |
| wr_data | input | 32 | Write data shared by both strobes |
| raw_stat | output | 32 | Sticky raw status word |
| masked_stat | output | 32 | Raw status qualified by the enables |
| irq | output | 1 | Level interrupt, OR of the masked word |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, three sources and the enable map 5/4/6. These values exercise the non-monotonic remap, in which raw bit order and control bit order disagree, and leave 29 upper data and control bits for the bench to toggle.

Random traffic sets the probabilities of events, clears and read-only writes so that bits build up and then drain. The enable patterns include every single-enable case and a control word with all bits set except the enables. Directed cycles cover the corner cases: a set and a clear of the same bit in one cycle, clears carrying only upper-bit data, and a reset in the middle of traffic.

// File: rtl/mis_pkg.sv
package mis_pkg;
   // Source indices in the raw / masked / clear layout
   typedef enum int unsigned {
      SRC_TXDONE = 0,
      SRC_RXRDY  = 1,
      SRC_RXOVF  = 2
   } mis_src_e;

   localparam int unsigned MIS_NSRC    = 3;
   localparam int unsigned MIS_POS_W   = 8;
   // Control-word position of each source enable, field i serves source i
   localparam logic [MIS_NSRC*MIS_POS_W-1:0] MIS_EN_MAP_DFLT =
      {8'd6, 8'd4, 8'd5};
endpackage

// File: rtl/mis_sticky_bit.sv
module mis_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= 1'b0;
      else if (set_i)
         q <= 1'b1;
      else if (clr_i)
         q <= 1'b0;
   end

   AST_SET_WINS:  assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q);                                  // R4
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && clr_i) |=> !q);                     // R3
   AST_STICKY:    assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q));            // R2
endmodule

// File: rtl/mis_enable_remap.sv
module mis_enable_remap #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NSRC   = 3,
   parameter int unsigned POS_W  = 8,
   parameter logic [NSRC*POS_W-1:0] EN_MAP = '0
) (
   input  logic [DATA_W-1:0] ctrl_word,
   output logic [NSRC-1:0]   en_o
);
   for (genvar i = 0; i < NSRC; i++) begin : g_en
      localparam int unsigned POS = int'(EN_MAP[i*POS_W +: POS_W]);
      initial begin
         assert (POS < DATA_W) else $error("enable position out of range");
      end
      assign en_o[i] = ctrl_word[POS];
   end
endmodule

// File: rtl/mis_clear_decode.sv
module mis_clear_decode #(
   parameter int unsigned NSRC = 3
) (
   input  logic            clr_we,
   input  logic [NSRC-1:0] wr_low,
   output logic [NSRC-1:0] clr_o
);
   for (genvar i = 0; i < NSRC; i++) begin : g_clr
      assign clr_o[i] = clr_we & wr_low[i];
   end
endmodule

// File: rtl/mis_irq_unit.sv
module mis_irq_unit #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NSRC   = mis_pkg::MIS_NSRC,
   parameter int unsigned POS_W  = mis_pkg::MIS_POS_W,
   parameter logic [NSRC*POS_W-1:0] EN_MAP = mis_pkg::MIS_EN_MAP_DFLT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   evt_i,
   input  logic [DATA_W-1:0] ctrl_word,
   input  logic              clr_we,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] raw_stat,
   output logic [DATA_W-1:0] masked_stat,
   output logic              irq
);
   localparam int unsigned PAD_W = DATA_W - NSRC;

   function automatic logic [DATA_W-1:0] en_mask_f();
      logic [DATA_W-1:0] m = '0;
      for (int i = 0; i < NSRC; i++) m[int'(EN_MAP[i*POS_W +: POS_W])] = 1'b1;
      return m;
   endfunction
   localparam logic [DATA_W-1:0] EN_MASK = en_mask_f();

   initial begin
      assert (NSRC > 0 && NSRC < DATA_W) else $error("NSRC must fit below DATA_W");
      assert ($countones(EN_MASK) == NSRC) else $error("enable positions must be distinct");
   end

   logic [NSRC-1:0] raw_q;
   logic [NSRC-1:0] en_w;
   logic [NSRC-1:0] clr_w;
   logic [NSRC-1:0] masked_w;

   mis_enable_remap #(
      .DATA_W(DATA_W), .NSRC(NSRC), .POS_W(POS_W), .EN_MAP(EN_MAP)
   ) u_remap (
      .ctrl_word(ctrl_word),
      .en_o     (en_w)
   );

   mis_clear_decode #(.NSRC(NSRC)) u_clr (
      .clr_we(clr_we),
      .wr_low(wr_data[NSRC-1:0]),
      .clr_o (clr_w)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      mis_sticky_bit u_bit (
         .clk  (clk),
         .rst_n(rst_n),
         .set_i(evt_i[i]),
         .clr_i(clr_w[i]),
         .q    (raw_q[i])
      );
   end

   assign masked_w    = raw_q & en_w;
   assign raw_stat    = {{PAD_W{1'b0}}, raw_q};
   assign masked_stat = {{PAD_W{1'b0}}, masked_w};
   assign irq         = |masked_w;

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (raw_stat == '0 && !irq));                        // R8
   AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (masked_stat & ~raw_stat) == '0);                            // R5
   AST_IRQ_LEVEL:   assert property (@(posedge clk) disable iff (!rst_n)
      irq == (masked_stat != '0));                                 // R6
   AST_RO_WRITE:    assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && !clr_we && evt_i == '0) |=> $stable(raw_stat));  // R7
   AST_CLR_UPPER:   assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && wr_data[NSRC-1:0] == '0 && wr_data[DATA_W-1:NSRC] != '0
       && evt_i == '0) |=> $stable(raw_stat));                     // R3
   AST_CTRL_OTHER:  assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(raw_stat) && ((ctrl_word ^ $past(ctrl_word)) & EN_MASK) == '0)
      |-> $stable(masked_stat));                                   // R5
endmodule

// File: tb/mis_irq_unit_tb.sv
`timescale 1ns/1ps
module mis_irq_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  evt_i = '0;
   logic [31:0] ctrl_word = '0;
   logic        clr_we = 1'b0;
   logic        stat_we = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] raw_stat, masked_stat;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [2:0] m_raw = '0;

   always #2 clk = ~clk;

   mis_irq_unit dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ctrl_word(ctrl_word),
      .clr_we(clr_we), .stat_we(stat_we), .wr_data(wr_data),
      .raw_stat(raw_stat), .masked_stat(masked_stat), .irq(irq)
   );

   function automatic logic [31:0] exp_mask(input logic [2:0] r, input logic [31:0] c);
      return {29'd0, r & {c[6], c[4], c[5]}};
   endfunction

   function automatic logic [2:0] exp_next(input logic [2:0] r, input logic [2:0] e,
                                           input logic cw, input logic [31:0] d);
      return (r & ~(cw ? d[2:0] : 3'b000)) | e;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive one cycle, check current outputs against the model, advance the model
   task automatic step(input logic [2:0] e, input logic cw, input logic sw,
                       input logic [31:0] d, input logic [31:0] c, input string req);
      @(negedge clk);
      evt_i = e; clr_we = cw; stat_we = sw; wr_data = d; ctrl_word = c;
      #0.5;
      check(req, "raw_stat", raw_stat, {29'd0, m_raw});
      check(req, "masked_stat", masked_stat, exp_mask(m_raw, c));
      check(req, "irq", {31'd0, irq}, {31'd0, exp_mask(m_raw, c) != 0});
      m_raw = rst_n ? exp_next(m_raw, e, cw, d) : 3'b000;
   endtask

   initial begin
      void'($urandom(32'h5a17));
      repeat (3) @(posedge clk);
      // R8: reset state
      step(3'b111, 1'b0, 1'b0, '0, 32'hFFFF_FFFF, "R8");
      step(3'b000, 1'b0, 1'b0, '0, 32'hFFFF_FFFF, "R8");
      @(negedge clk); rst_n = 1'b1;
      // R1 R2: done pulse, no enables
      step(3'b001, 1'b0, 1'b0, '0, '0, "R1");
      step(3'b000, 1'b0, 1'b0, '0, '0, "R2");
      step(3'b000, 1'b0, 1'b0, '0, '0, "R2");
      // R5 R6: enable done via control bit 5
      step(3'b000, 1'b0, 1'b0, '0, 32'h20, "R5");
      step(3'b000, 1'b0, 1'b0, '0, 32'h20, "R6");
      // R7: read-only write with all ones
      step(3'b000, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h20, "R7");
      step(3'b000, 1'b0, 1'b1, 32'h0, 32'h20, "R7");
      // R3: clear with zero low bits / data without strobe
      step(3'b000, 1'b1, 1'b0, 32'hFFFF_FFF8, 32'h20, "R3");
      step(3'b000, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h20, "R3");
      // R4: set and clear together
      step(3'b001, 1'b1, 1'b0, 32'h1, 32'h20, "R4");
      step(3'b000, 1'b0, 1'b0, 32'h0, 32'h20, "R4");
      // R3: real clear
      step(3'b000, 1'b1, 1'b0, 32'h1, 32'h20, "R3");
      step(3'b110, 1'b0, 1'b0, 32'h0, 32'h20, "R3");
      // R5: each single enable, then every other control bit
      step(3'b001, 1'b0, 1'b0, 32'h0, 32'h10, "R5");
      step(3'b000, 1'b0, 1'b0, 32'h0, 32'h10, "R5");
      step(3'b000, 1'b0, 1'b0, 32'h0, 32'h40, "R5");
      step(3'b000, 1'b0, 1'b0, 32'h0, 32'h20, "R5");
      step(3'b000, 1'b0, 1'b0, 32'h0, 32'hFFFF_FF8F, "R5");
      step(3'b000, 1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF, "R6");
      // random traffic
      for (int k = 0; k < 4000; k++) begin
         logic [2:0]  e;
         logic        cw, sw;
         logic [31:0] d, c;
         e  = 3'($urandom) & 3'($urandom) & 3'($urandom);
         cw = ($urandom % 4) == 0;
         sw = ($urandom % 5) == 0;
         d  = $urandom;
         c  = $urandom;
         step(e, cw, sw, d, c, "R2");
      end
      // R8: reset in mid traffic
      step(3'b111, 1'b0, 1'b0, 32'h0, 32'h70, "R8");
      @(negedge clk); rst_n = 1'b0;
      m_raw = 3'b000;
      step(3'b000, 1'b0, 1'b0, 32'h0, 32'h70, "R8");
      step(3'b000, 1'b0, 1'b0, 32'h0, 32'h70, "R8");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule